// File: doc/BRIEF.md
# LCD Colour Palette Lookup

This block turns palettized pixel indices into colour words for an LCD output pipeline. A 256-entry table of 16-bit colours is kept as 128 storage words of 32 bits. Each word holds two neighbouring entries. The table is loaded through a 32-bit register-style write port. That port has a per-byte enable, so one entry can be rewritten without touching the entry that shares its word.

On the read side the block takes one pixel per cycle, qualified by a valid flag. Exactly one clock later it presents the looked-up colour with its own valid flag. The pixel mode tells the block how many index bits are meaningful, and index bits above that width are cleared before the lookup. In the two true-colour modes the table is skipped and the pixel value is passed to the output unchanged, with the same one-clock latency.

A write and a lookup may hit the same storage word in one cycle. In that case the lookup returns the contents as they were before the write.

Top module: `lcdPaletteLut`

## Requirements
- R1: While reset is held, and in the cycle after it is released, colValid is 0 and colData is 0.
- R2: A write with wrEn=1 updates storage word wrAddr. Byte lane b (wrByteEn[b]) carries wrData[8b+7:8b]. Palette entry 2k is held in bits [15:0] of word k and entry 2k+1 in bits [31:16].
- R3: A write whose byte enables cover only one half-word changes only the entry stored in that half. The neighbouring entry reads back unchanged.
- R4: In 8 bpp mode (pixMode=3), colData is {8'h00, entry[pixData[7:0]]}. It appears one clock after the cycle that presents pixValid=1.
- R5: colValid equals pixValid of the previous clock cycle.
- R6: In modes below 8 bpp, only the low index bits are used and the rest are cleared before the lookup: pixMode=0 (1 bpp) uses pixData[0], pixMode=1 (2 bpp) uses [1:0], pixMode=2 (4 bpp) uses [3:0].
- R7: In 16 bpp true-colour mode (pixMode=4), colData is {8'h00, pixData[15:0]}, one clock later, without any lookup.
- R8: In 24 bpp true-colour mode (pixMode=5, and also the codes 6 and 7), colData equals pixData, one clock later.
- R9: When a write and a lookup address the same word in the same cycle, the lookup returns the word's contents from before the write. The new contents are seen from the next lookup onward.
- R10: While pixValid is 0, colData holds its last value.
- R11: In palettized modes, colData[23:16] is 0 whenever colValid is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Palette write strobe |
| wrAddr | input | 7 | Storage word address |
| wrData | input | 32 | Write data, two entries |
| wrByteEn | input | 4 | Per-byte write enables |
| pixMode | input | 3 | 0..3: 1/2/4/8 bpp palettized; 4: 16 bpp; 5..7: 24 bpp |
| pixValid | input | 1 | Pixel index valid |
| pixData | input | 24 | Pixel index or true-colour value |
| colValid | output | 1 | Colour output valid |
| colData | output | 24 | Colour output |

## Verification
Every pixel result, whether looked up or bypassed, is due on the first rising edge after the cycle that presents it. The bench therefore drives each pixel on a falling edge and samples colData and colValid on the next falling edge, half a period after the result register loads. A write becomes visible to lookups presented from the edge after it is captured onward. The collision test checks that the lookup sharing the write's edge still sees the old word, and that the next lookup sees the new one. In the hold test, pixValid stays low for several falling edges while pixData changes, and colData is compared against the last valid result on each of them.

// File: rtl/lcdPalPkg.sv
package lcdPalPkg;
  localparam int ENTRY_W  = 16;
  localparam int WORD_W   = 32;
  localparam int ENTRIES  = 256;
  localparam int WORDS    = ENTRIES / (WORD_W / ENTRY_W);
  localparam int WADDR_W  = $clog2(WORDS);
  localparam int IDX_W    = $clog2(ENTRIES);
  localparam int PIX_W    = 24;
  localparam int LANES    = WORD_W / 8;

  typedef enum logic [2:0] {
    PM_BPP1  = 3'd0,
    PM_BPP2  = 3'd1,
    PM_BPP4  = 3'd2,
    PM_BPP8  = 3'd3,
    PM_BPP16 = 3'd4,
    PM_BPP24 = 3'd5
  } pixMode_e;

  typedef struct packed {
    logic               rdEn;
    logic [WADDR_W-1:0] rdWord;
    logic               rdHalf;
    logic               pass16;
    logic               pass24;
    logic [PIX_W-1:0]   pix;
    logic               wrEn;
    logic [WADDR_W-1:0] wrWord;
    logic [WORD_W-1:0]  wrData;
    logic [LANES-1:0]   wrLanes;
  } palStrobe_t;
endpackage

// File: rtl/lcdPalCtrl.sv
module lcdPalCtrl
  import lcdPalPkg::*;
#(
  parameter int IDX_BITS = IDX_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [WADDR_W-1:0] wrAddr,
  input  logic [WORD_W-1:0]  wrData,
  input  logic [LANES-1:0]   wrByteEn,
  input  logic [2:0]         pixMode,
  input  logic               pixValid,
  input  logic [PIX_W-1:0]   pixData,
  output palStrobe_t         strobes
);
  localparam int MAX_BPP_LOG = $clog2(IDX_BITS);

  logic [IDX_BITS-1:0] idxMask;
  logic [IDX_BITS-1:0] idxUsed;
  int unsigned         bppBits;
  logic                isPass16;
  logic                isPass24;

  always_comb begin
    isPass16 = 1'b0;
    isPass24 = 1'b0;
    bppBits  = IDX_BITS;
    unique case (pixMode)
      PM_BPP1:  bppBits = 1;
      PM_BPP2:  bppBits = 2;
      PM_BPP4:  bppBits = 4;
      PM_BPP8:  bppBits = 1 << MAX_BPP_LOG;
      PM_BPP16: isPass16 = 1'b1;
      default:  isPass24 = 1'b1;
    endcase
    if (bppBits >= IDX_BITS) idxMask = '1;
    else                     idxMask = IDX_BITS'((1 << bppBits) - 1);
    idxUsed = pixData[IDX_BITS-1:0] & idxMask;
  end

  always_comb begin
    strobes.rdEn    = pixValid;
    strobes.rdWord  = idxUsed[IDX_BITS-1:1];
    strobes.rdHalf  = idxUsed[0];
    strobes.pass16  = isPass16;
    strobes.pass24  = isPass24;
    strobes.pix     = pixData;
    strobes.wrEn    = wrEn;
    strobes.wrWord  = wrAddr;
    strobes.wrData  = wrData;
    strobes.wrLanes = wrByteEn;
  end

  // R6: a 1 bpp index can only reach word 0; a 4 bpp index stays within the first 8 words
  a_r6_mask_bpp1: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && pixMode == 3'd0) |-> (strobes.rdWord == '0));
  a_r6_mask_bpp4: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && pixMode == 3'd2) |-> (strobes.rdWord < WADDR_W'(8)));
endmodule

// File: rtl/lcdPalData.sv
module lcdPalData
  import lcdPalPkg::*;
#(
  parameter int NUM_WORDS = WORDS
) (
  input  logic             clk,
  input  logic             rstN,
  input  palStrobe_t       strobes,
  output logic             colValid,
  output logic [PIX_W-1:0] colData
);
  logic [WORD_W-1:0] palMem [NUM_WORDS];

  logic [WORD_W-1:0] wordQ;
  logic              halfQ;
  logic              pass16Q;
  logic              pass24Q;
  logic [PIX_W-1:0]  pixQ;
  logic              validQ;
  logic [ENTRY_W-1:0] entrySel;

  // write: per-lane update, sampled after the read below (read-before-write)
  always_ff @(posedge clk) begin
    if (strobes.wrEn) begin
      for (int b = 0; b < LANES; b++) begin
        if (strobes.wrLanes[b]) palMem[strobes.wrWord][b*8 +: 8] <= strobes.wrData[b*8 +: 8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ  <= 1'b0;
      wordQ   <= '0;
      halfQ   <= 1'b0;
      pass16Q <= 1'b0;
      pass24Q <= 1'b0;
      pixQ    <= '0;
    end else begin
      validQ <= strobes.rdEn;
      if (strobes.rdEn) begin
        wordQ   <= palMem[strobes.rdWord];
        halfQ   <= strobes.rdHalf;
        pass16Q <= strobes.pass16;
        pass24Q <= strobes.pass24;
        pixQ    <= strobes.pix;
      end
    end
  end

  assign entrySel = halfQ ? wordQ[WORD_W-1:ENTRY_W] : wordQ[ENTRY_W-1:0];

  always_comb begin
    if (pass24Q)      colData = pixQ;
    else if (pass16Q) colData = {{(PIX_W-ENTRY_W){1'b0}}, pixQ[ENTRY_W-1:0]};
    else              colData = {{(PIX_W-ENTRY_W){1'b0}}, entrySel};
  end
  assign colValid = validQ;

  // R11: palettized results never carry upper colour bits
  a_r11_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    (colValid && !pass24Q && !pass16Q) |-> (colData[PIX_W-1:ENTRY_W] == '0));
endmodule

// File: rtl/lcdPaletteLut.sv
module lcdPaletteLut
  import lcdPalPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [WADDR_W-1:0] wrAddr,
  input  logic [WORD_W-1:0]  wrData,
  input  logic [LANES-1:0]   wrByteEn,
  input  logic [2:0]         pixMode,
  input  logic               pixValid,
  input  logic [PIX_W-1:0]   pixData,
  output logic               colValid,
  output logic [PIX_W-1:0]   colData
);
  palStrobe_t strobes;

  lcdPalCtrl #(.IDX_BITS(IDX_W)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .wrByteEn(wrByteEn), .pixMode(pixMode), .pixValid(pixValid),
    .pixData(pixData), .strobes(strobes)
  );

  lcdPalData #(.NUM_WORDS(WORDS)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .colValid(colValid), .colData(colData)
  );

  // R5: output valid follows input valid by one clock
  a_r5_valid_rise: assert property (@(posedge clk) disable iff (!rstN)
    pixValid |=> colValid);
  a_r5_valid_low: assert property (@(posedge clk) disable iff (!rstN)
    !pixValid |=> !colValid);
  // R8: 24 bpp pixels come out unchanged
  a_r8_pass24: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && pixMode >= 3'd5) |=> (colData == $past(pixData)));
  // R10: output is held while no pixel is presented
  a_r10_hold: assert property (@(posedge clk) disable iff (!rstN)
    !pixValid |=> $stable(colData));
endmodule

// File: tb/sim_lcdPaletteLut.sv
module sim_lcdPaletteLut;
  logic        clk = 1'b0;
  logic        rstN;
  logic        wrEn;
  logic [6:0]  wrAddr;
  logic [31:0] wrData;
  logic [3:0]  wrByteEn;
  logic [2:0]  pixMode;
  logic        pixValid;
  logic [23:0] pixData;
  logic        colValid;
  logic [23:0] colData;

  int checks = 0;
  int fails  = 0;
  logic [15:0] model [256];

  always #2 clk = ~clk;

  lcdPaletteLut u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .wrByteEn(wrByteEn), .pixMode(pixMode), .pixValid(pixValid),
    .pixData(pixData), .colValid(colValid), .colData(colData)
  );

  // stimulus table: {mode, pixel}
  localparam int NV = 12;
  localparam logic [26:0] VEC [NV] = '{
    {3'd3, 24'h000000}, {3'd3, 24'h0000FF}, {3'd3, 24'h000081},
    {3'd3, 24'h123456}, {3'd0, 24'h0000FF}, {3'd0, 24'h0000FE},
    {3'd1, 24'h0000FE}, {3'd2, 24'h0000AB}, {3'd2, 24'h00FFF7},
    {3'd4, 24'hABCDEF}, {3'd5, 24'hABCDEF}, {3'd7, 24'h13579B}
  };

  function automatic logic [15:0] initEntry(int i);
    return {8'(i) ^ 8'h5A, ~8'(i)};
  endfunction

  function automatic logic [23:0] expect_col(logic [2:0] m, logic [23:0] p);
    case (m)
      3'd0: return {8'h00, model[{7'd0, p[0]}]};
      3'd1: return {8'h00, model[{6'd0, p[1:0]}]};
      3'd2: return {8'h00, model[{4'd0, p[3:0]}]};
      3'd3: return {8'h00, model[p[7:0]]};
      3'd4: return {8'h00, p[15:0]};
      default: return p;
    endcase
  endfunction

  function automatic string reqOf(logic [2:0] m);
    case (m)
      3'd3: return "R4";
      3'd4: return "R7";
      3'd0, 3'd1, 3'd2: return "R6";
      default: return "R8";
    endcase
  endfunction

  task automatic check(string req, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic writeWord(logic [6:0] a, logic [31:0] d, logic [3:0] be);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d; wrByteEn = be;
    @(negedge clk);
    wrEn = 1'b0; wrByteEn = '0;
    if (be[0]) model[{a, 1'b0}][7:0]  = d[7:0];
    if (be[1]) model[{a, 1'b0}][15:8] = d[15:8];
    if (be[2]) model[{a, 1'b1}][7:0]  = d[23:16];
    if (be[3]) model[{a, 1'b1}][15:8] = d[31:24];
  endtask

  // drive on a falling edge, sample on the next falling edge (one clock latency)
  task automatic lookup(string req, logic [2:0] m, logic [23:0] p, logic [23:0] exp);
    @(negedge clk);
    pixValid = 1'b1; pixMode = m; pixData = p;
    @(negedge clk);
    pixValid = 1'b0;
    check({req, " valid (R5)"}, {23'd0, colValid}, 24'd1);
    check(req, colData, exp);
  endtask

  initial begin
    #(4 * 200000);
    $display("FAIL watchdog: actual timeout expected completion");
    fails++;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [23:0] last;
    rstN = 1'b0; wrEn = 1'b0; wrAddr = '0; wrData = '0; wrByteEn = '0;
    pixMode = 3'd3; pixValid = 1'b0; pixData = '0;
    repeat (3) @(negedge clk);
    check("R1 reset colValid", {23'd0, colValid}, 24'd0);
    check("R1 reset colData", colData, 24'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after release colValid", {23'd0, colValid}, 24'd0);
    check("R1 after release colData", colData, 24'd0);

    // R2: load the full table
    for (int k = 0; k < 128; k++)
      writeWord(7'(k), {initEntry(2*k+1), initEntry(2*k)}, 4'hF);
    check("R2 table entry 0x81", {8'h00, model[8'h81]}, {8'h00, initEntry(8'h81)});

    for (int v = 0; v < NV; v++)
      lookup(reqOf(VEC[v][26:24]), VEC[v][26:24], VEC[v][23:0],
             expect_col(VEC[v][26:24], VEC[v][23:0]));

    // R3: half-word update leaves neighbour untouched
    writeWord(7'd5, 32'hFFFF_BEEF, 4'b0011);
    lookup("R3 written half", 3'd3, 24'h00000A, 24'h00BEEF);
    lookup("R3 neighbour", 3'd3, 24'h00000B, {8'h00, initEntry(11)});
    // R2: single byte lane
    writeWord(7'd5, 32'h00C3_0000, 4'b0100);
    lookup("R2 byte lane 2", 3'd3, 24'h00000B, {8'h00, initEntry(11)} & 24'h00FF00 | 24'h0000C3);

    // R9: collision returns old word, then new
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 7'd6; wrData = 32'h1111_2222; wrByteEn = 4'hF;
    pixValid = 1'b1; pixMode = 3'd3; pixData = 24'h00000C;
    @(negedge clk);
    wrEn = 1'b0; wrByteEn = '0; pixValid = 1'b0;
    check("R9 collision old", colData, {8'h00, model[12]});
    model[12] = 16'h2222; model[13] = 16'h1111;
    lookup("R9 after write", 3'd3, 24'h00000C, 24'h002222);

    // R10: hold while idle
    lookup("R4 before hold", 3'd3, 24'h00000D, 24'h001111);
    last = colData;
    for (int i = 0; i < 3; i++) begin
      pixData = 24'hFFFFFF - 24'(i);
      @(negedge clk);
      check("R10 hold colValid (R5)", {23'd0, colValid}, 24'd0);
      check("R10 hold colData", colData, last);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule